// File: doc/BRIEF.md
# Receive Completion Interrupt Coalescer

This block decides when one receive channel raises a completion event toward software. Each frame that the datapath finishes writing into the completion ring is reported with a one-cycle strobe, and the block keeps a count of frames that software has not yet taken. Software reports back how many packets it has consumed, and the pending count falls by that amount, never below zero.

An event fires when the pending count climbs above a programmed threshold, or when a countdown timeout runs out while at least one frame is pending. The countdown advances on a coarse tick that a free-running prescaler derives from the system clock. The timer holds its reload value while nothing is pending, reloads on every event, and can be switched off, which leaves the threshold as the only automatic trigger. Software may also force an event at any moment with a flush command. Each event is a one-cycle pulse. It also sets a sticky status flag that records whether the timer or the threshold caused it.

Configuration goes through a small write port at four addresses. Address 0 holds the timeout in ticks: only 1 to 63 is accepted, and any other value is dropped, so the previous value stays. Address 1 holds the threshold: only 1 to 511 is accepted. Address 2 holds the 16-bit tick divider, where a value of N gives a tick every N clocks and 0 or 1 gives a tick every clock. Address 3 is control: bit 0 enables the timeout, a 1 in bit 1 issues a flush, and a 1 in bit 2 clears both status flags.

Top module: `rx_cmpl_coalescer`

## Requirements
- R1: After reset, pending_o is 0, event_o is 0 and both status flags are 0. The reset values are timeout 8 ticks, threshold 16, divider 4 and timeout enabled.
- R2: On each clock edge the pending count becomes old count plus frame_done_i minus consume_cnt_i (when consume_valid_i is 1), saturating at 0 when the consume value is larger. It saturates at the all-ones maximum when increasing.
- R3: When the registered pending count first becomes greater than the threshold, event_o pulses on the following clock and stat_thresh_o is set. No further threshold event occurs while the count stays above the threshold.
- R4: With the timeout enabled and divider 1, a single frame arriving at an idle channel produces an event exactly timeout+1 sampled cycles after the strobe edge, and stat_timeout_o is set.
- R5: With control bit 0 at 0, no timeout event occurs and stat_timeout_o stays 0, however long frames remain pending.
- R6: A timeout write of 0 or of 64 and above is ignored, and so is a threshold write of 0 or of 512 and above. The previous values remain in force.
- R7: While frames stay pending, consecutive timeout events are timeout × divider clock cycles apart (divider ≥ 1).
- R8: A control write with bit 1 set produces an event on the next clock whatever the count and timer show, and sets neither status flag.
- R9: Status flags stay set until a control write with bit 2 set clears them. A set in the same cycle wins over the clear. event_o lasts one cycle per trigger cycle.
- R10: While the pending count is 0, the timer does not run and no timeout event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address (0 timeout, 1 threshold, 2 divider, 3 control) |
| cfg_wdata_i | input | 16 | Configuration write data |
| frame_done_i | input | 1 | One-cycle strobe per completed frame |
| consume_valid_i | input | 1 | Software consume update valid |
| consume_cnt_i | input | 16 | Number of packets software has consumed |
| event_o | output | 1 | Completion event pulse |
| pending_o | output | 16 | Current pending frame count |
| stat_timeout_o | output | 1 | Sticky flag: an event came from the timer |
| stat_thresh_o | output | 1 | Sticky flag: an event came from the threshold |

## Verification
Single isolated frames on an idle channel measure the timer latency in cycles. A held pending count with divider 4 measures the recurrence interval, which separates tick generation from the countdown itself. A burst of back-to-back frames against a low threshold with the timer disabled checks that exactly one crossing event occurs and that no timeout leaks through. The illegal configuration writes are judged by re-measuring the latency afterwards. A long pseudo-random mix of strobes, consumes larger and smaller than the count, and flushes is compared with a behavioural model on every clock, which catches off-by-one saturation and ordering errors between reload, tick and flush.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    CA_TIMEOUT = 2'd0,
    CA_THRESH  = 2'd1,
    CA_DIVIDER = 2'd2,
    CA_CONTROL = 2'd3
  } cfg_addr_e;

  localparam int CTL_TO_EN = 0;
  localparam int CTL_FLUSH = 1;
  localparam int CTL_CLEAR = 2;
endpackage

// File: rtl/coal_cfg.sv
module coal_cfg #(
  parameter int DATA_W  = 16,
  parameter int TO_W    = 6,
  parameter int THR_W   = 9,
  parameter int DIV_W   = 16,
  parameter int TO_RST  = 8,
  parameter int THR_RST = 16,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [TO_W-1:0]   to_q,
  output logic [THR_W-1:0]  thr_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              to_en_q,
  output logic              flush_o,
  output logic              clr_o
);
  import coal_pkg::*;

  logic [TO_W-1:0]  to_d;
  logic [THR_W-1:0] thr_d;
  logic [DIV_W-1:0] div_d;
  logic             to_en_d;
  logic             to_legal, thr_legal;
  logic             sel_to, sel_thr, sel_div, sel_ctl;

  always_comb begin
    sel_to    = we && (addr == CA_TIMEOUT);
    sel_thr   = we && (addr == CA_THRESH);
    sel_div   = we && (addr == CA_DIVIDER);
    sel_ctl   = we && (addr == CA_CONTROL);
    to_legal  = (wdata != '0) && ((wdata >> TO_W) == '0);
    thr_legal = (wdata != '0) && ((wdata >> THR_W) == '0);
    to_d      = (sel_to && to_legal) ? wdata[TO_W-1:0] : to_q;
    thr_d     = (sel_thr && thr_legal) ? wdata[THR_W-1:0] : thr_q;
    div_d     = sel_div ? wdata[DIV_W-1:0] : div_q;
    to_en_d   = sel_ctl ? wdata[CTL_TO_EN] : to_en_q;
    flush_o   = sel_ctl && wdata[CTL_FLUSH];
    clr_o     = sel_ctl && wdata[CTL_CLEAR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q    <= TO_W'(TO_RST);
      thr_q   <= THR_W'(THR_RST);
      div_q   <= DIV_W'(DIV_RST);
      to_en_q <= 1'b1;
    end else begin
      to_q    <= to_d;
      thr_q   <= thr_d;
      div_q   <= div_d;
      to_en_q <= to_en_d;
    end
  end
endmodule

// File: rtl/coal_prescaler.sv
module coal_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DIV_W:0]   pre_inc;

  always_comb begin
    pre_inc = {1'b0, pre_q} + (DIV_W+1)'(1);
    tick    = (pre_inc >= {1'b0, div});
    pre_d   = tick ? '0 : pre_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/coal_pending.sv
module coal_pending #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             consume_valid,
  input  logic [CNT_W-1:0] consume_cnt,
  output logic [CNT_W-1:0] pend_q,
  output logic             busy
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [SUM_W-1:0] sum, rem;
  logic [CNT_W-1:0] pend_d;

  always_comb begin
    sum = {1'b0, pend_q} + SUM_W'(frame);
    rem = sum;
    if (consume_valid) begin
      rem = (sum >= {1'b0, consume_cnt}) ? (sum - {1'b0, consume_cnt}) : '0;
    end
    pend_d = (rem > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : rem[CNT_W-1:0];
    busy   = (pend_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TO_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            busy,
  input  logic            reload,
  input  logic [TO_W-1:0] to_val,
  output logic            expire
);
  logic [TO_W-1:0] tmr_q, tmr_d;

  always_comb begin
    expire = busy && tick && (tmr_q == TO_W'(1));
    tmr_d  = tmr_q;
    if (!busy || reload) begin
      tmr_d = to_val;
    end else if (tick) begin
      tmr_d = (tmr_q == TO_W'(1)) ? to_val : (tmr_q - TO_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/rx_cmpl_coalescer.sv
module rx_cmpl_coalescer #(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int TO_W    = 6,
  parameter int THR_W   = 9,
  parameter int DIV_W   = 16,
  parameter int TO_RST  = 8,
  parameter int THR_RST = 16,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              frame_done_i,
  input  logic              consume_valid_i,
  input  logic [CNT_W-1:0]  consume_cnt_i,
  output logic              event_o,
  output logic [CNT_W-1:0]  pending_o,
  output logic              stat_timeout_o,
  output logic              stat_thresh_o
);
  localparam int PAD_W = CNT_W - THR_W;

  logic [TO_W-1:0]  to_q;
  logic [THR_W-1:0] thr_q;
  logic [DIV_W-1:0] div_q;
  logic             to_en_q, flush, clr;
  logic             tick, busy, expire;
  logic [CNT_W-1:0] pend_q;
  logic             above, above_q;
  logic             thr_fire, to_fire, any_fire;
  logic             evt_q, st_to_q, st_thr_q;
  logic             st_to_d, st_thr_d;

  coal_cfg #(
    .DATA_W(DATA_W), .TO_W(TO_W), .THR_W(THR_W), .DIV_W(DIV_W),
    .TO_RST(TO_RST), .THR_RST(THR_RST), .DIV_RST(DIV_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .addr(cfg_addr_i),
    .wdata(cfg_wdata_i), .to_q(to_q), .thr_q(thr_q), .div_q(div_q),
    .to_en_q(to_en_q), .flush_o(flush), .clr_o(clr)
  );

  coal_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  coal_pending #(.CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .frame(frame_done_i),
    .consume_valid(consume_valid_i), .consume_cnt(consume_cnt_i),
    .pend_q(pend_q), .busy(busy)
  );

  coal_timer #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .reload(any_fire), .to_val(to_q), .expire(expire)
  );

  always_comb begin
    above    = pend_q > {{PAD_W{1'b0}}, thr_q};
    thr_fire = above && !above_q;
    to_fire  = expire && to_en_q;
    any_fire = thr_fire || to_fire || flush;
    st_to_d  = to_fire  ? 1'b1 : (clr ? 1'b0 : st_to_q);
    st_thr_d = thr_fire ? 1'b1 : (clr ? 1'b0 : st_thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q  <= 1'b0;
      evt_q    <= 1'b0;
      st_to_q  <= 1'b0;
      st_thr_q <= 1'b0;
    end else begin
      above_q  <= above;
      evt_q    <= any_fire;
      st_to_q  <= st_to_d;
      st_thr_q <= st_thr_d;
    end
  end

  assign event_o        = evt_q;
  assign pending_o      = pend_q;
  assign stat_timeout_o = st_to_q;
  assign stat_thresh_o  = st_thr_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              frame,
  input logic              consume_valid,
  input logic [CNT_W-1:0]  consume_cnt,
  input logic              evt,
  input logic [CNT_W-1:0]  pend,
  input logic              st_to,
  input logic              st_thr,
  input logic              to_en
);
  logic ctl_wr, clr_wr, flush_wr;
  logic [CNT_W:0] pend_plus;
  logic [CNT_W-1:0] cnt_max;
  assign ctl_wr    = cfg_we && (cfg_addr == 2'd3);
  assign clr_wr    = ctl_wr && cfg_wdata[2];
  assign flush_wr  = ctl_wr && cfg_wdata[1];
  assign pend_plus = {1'b0, pend} + (CNT_W+1)'(frame);
  assign cnt_max   = '1;

  AST_PEND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_valid && ({1'b0, consume_cnt} >= pend_plus)) |=> (pend == '0)); // R2

  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !consume_valid && pend != cnt_max) |=> (pend == $past(pend) + 1'b1)); // R2

  AST_THR_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_thr) |-> evt); // R3

  AST_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_en && !st_to) |=> !st_to); // R5

  AST_FLUSH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> evt); // R8

  AST_STICKY_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_to && !clr_wr) |=> st_to); // R9

  AST_STICKY_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_thr && !clr_wr) |=> st_thr); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !st_to) |=> !st_to); // R10
endmodule

bind rx_cmpl_coalescer coal_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .cfg_addr(cfg_addr_i),
  .cfg_wdata(cfg_wdata_i), .frame(frame_done_i),
  .consume_valid(consume_valid_i), .consume_cnt(consume_cnt_i),
  .evt(event_o), .pend(pending_o), .st_to(stat_timeout_o),
  .st_thr(stat_thresh_o), .to_en(to_en_q)
);

// File: tb/rx_cmpl_coalescer_tb_top.sv
`timescale 1ns/1ps
module rx_cmpl_coalescer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        frame;
  logic        cv;
  logic [15:0] cc;
  logic        evt;
  logic [15:0] pend;
  logic        st_to, st_thr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R1";

  rx_cmpl_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_done_i(frame), .consume_valid_i(cv),
    .consume_cnt_i(cc), .event_o(evt), .pending_o(pend),
    .stat_timeout_o(st_to), .stat_thresh_o(st_thr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  int m_pend, m_thr, m_to, m_div, m_pre, m_tmr;
  bit m_en, m_above, m_evt, m_sto, m_sthr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_thr = 16; m_to = 8; m_div = 4; m_pre = 0; m_tmr = 0;
      m_en = 1; m_above = 0; m_evt = 0; m_sto = 0; m_sthr = 0;
    end else begin
      bit tk, bz, ab, tf, of, fl, cl, any;
      int n;
      tk  = (m_pre + 1 >= m_div);
      bz  = (m_pend != 0);
      ab  = (m_pend > m_thr);
      tf  = ab && !m_above;
      of  = m_en && bz && tk && (m_tmr == 1);
      fl  = cfg_we && cfg_addr == 2'd3 && cfg_wdata[1];
      cl  = cfg_we && cfg_addr == 2'd3 && cfg_wdata[2];
      any = tf || of || fl;
      if (!bz || any) m_tmr = m_to;
      else if (tk) m_tmr = (m_tmr == 1) ? m_to : m_tmr - 1;
      m_pre   = tk ? 0 : m_pre + 1;
      m_above = ab;
      m_evt   = any;
      if (of) m_sto = 1; else if (cl) m_sto = 0;
      if (tf) m_sthr = 1; else if (cl) m_sthr = 0;
      n = m_pend + int'(frame);
      if (cv) n = (n >= int'(cc)) ? n - int'(cc) : 0;
      if (n > 65535) n = 65535;
      m_pend = n;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: if (cfg_wdata >= 1 && cfg_wdata <= 63) m_to = cfg_wdata;
          2'd1: if (cfg_wdata >= 1 && cfg_wdata <= 511) m_thr = cfg_wdata;
          2'd2: m_div = cfg_wdata;
          default: m_en = cfg_wdata[0];
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " event"}, int'(evt), int'(m_evt));
      chk({cur_req, " pending"}, int'(pend), m_pend);
      chk({cur_req, " stat_timeout"}, int'(st_to), int'(m_sto));
      chk({cur_req, " stat_thresh"}, int'(st_thr), int'(m_sthr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic consume(input int k);
    cv = 1; cc = 16'(k);
    @(negedge clk);
    cv = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic latency(output int n);
    frame = 1;
    @(negedge clk);
    frame = 0;
    n = 1;
    while (!evt && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic count_evt(input int k, output int e);
    e = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (evt) e++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, e;
    logic [7:0] lfsr;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    frame = 0; cv = 0; cc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 pend", int'(pend), 0);
    chk("R1 evt", int'(evt), 0);
    chk("R1 stat", int'({st_to, st_thr}), 0);

    cur_req = "R2";
    wr(2'd3, 16'h0000);
    frame = 1; idle(5); frame = 0;
    chk("R2 count", int'(pend), 5);
    consume(2);
    chk("R2 consume", int'(pend), 3);
    consume(10);
    chk("R2 floor", int'(pend), 0);

    cur_req = "R4";
    wr(2'd2, 16'd1); wr(2'd0, 16'd5); wr(2'd3, 16'h0001);
    idle(2);
    latency(n);
    chk("R4 latency", n, 6);
    chk("R4 stat_timeout", int'(st_to), 1);
    consume(1);

    cur_req = "R9";
    wr(2'd3, 16'h0005);
    chk("R9 clear", int'(st_to), 0);

    cur_req = "R10";
    count_evt(50, e);
    chk("R10 idle events", e, 0);
    chk("R10 idle stat", int'(st_to), 0);

    cur_req = "R6";
    wr(2'd0, 16'd0); wr(2'd0, 16'd64); wr(2'd1, 16'd0); wr(2'd1, 16'd600);
    idle(2);
    latency(n);
    chk("R6 timeout kept", n, 6);
    consume(1);
    wr(2'd3, 16'h0005);

    cur_req = "R7";
    wr(2'd2, 16'd4); wr(2'd0, 16'd3);
    idle(2);
    latency(n);
    n = 0;
    do begin @(negedge clk); n++; end while (!evt && n < 500);
    chk("R7 interval", n, 12);
    consume(1);

    cur_req = "R3";
    wr(2'd3, 16'h0004); wr(2'd1, 16'd3); wr(2'd2, 16'd1);
    idle(2);
    frame = 1;
    e = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (evt) e++; end
    frame = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (evt) e++; end
    chk("R3 one crossing", e, 1);
    chk("R3 stat_thresh", int'(st_thr), 1);

    cur_req = "R5";
    count_evt(40, e);
    chk("R5 no timeout", e, 0);
    chk("R5 stat", int'(st_to), 0);
    consume(4);
    wr(2'd3, 16'h0004);

    cur_req = "R8";
    wr(2'd3, 16'h0002);
    chk("R8 flush event", int'(evt), 1);
    chk("R8 no status", int'({st_to, st_thr}), 0);
    @(negedge clk);
    chk("R9 pulse", int'(evt), 0);

    cur_req = "R2";
    wr(2'd1, 16'd20); wr(2'd0, 16'd7); wr(2'd2, 16'd3); wr(2'd3, 16'h0001);
    lfsr = 8'h5A;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      frame = lfsr[0] | lfsr[1];
      cv = (lfsr[7:4] == 4'h3);
      cc = 16'(lfsr[3:0] * 2);
      cfg_we = (lfsr == 8'h11) || (lfsr == 8'h2C);
      cfg_addr = 2'd3;
      cfg_wdata = (lfsr == 8'h11) ? 16'h0003 : 16'h0005;
      @(negedge clk);
    end
    frame = 0; cv = 0; cfg_we = 0;
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule